// File: doc/BRIEF.md
# Three-Bit Software Watchdog Timer

This block guards a low-power microcontroller against a program that has lost its way. A three-bit up counter steps once for every strobe of a 2 Hz time base that comes from the clock-timer prescaler. When the counter steps past its top value of 7, its most significant bit overflows. The block then raises an initial-reset request for one system-clock cycle and the counter starts again from zero.

Software keeps the chip alive by writing a one into the restart bit (bit 3) of a 4-bit memory-mapped control word. That write clears the counter, and counting resumes on the next strobe. Bit 3 is write-only and always reads back as zero. Bits 2 to 0 return the live counter. Bit 0 is the 1 Hz stage, bit 1 the 1/2 Hz stage and bit 2 the 1/4 Hz stage.

The block has no halt or stop input, so it keeps counting while the CPU is halted. A static enable, tied at integration time, switches the whole function off. With the enable low, software never needs to restart it. If software stops restarting it, the request follows 3.5 to 4 seconds after the last restart. The prescaler and the logic that merges reset sources sit outside this block.

Top module: `wdt_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the read word is 4'b0000 and the reset request is low.
- R2: With the block enabled and no restart write, a tick strobe on a count below 7 raises the count by exactly one at that clock edge.
- R3: With the block enabled and no restart write, a cycle without a tick strobe leaves the count unchanged.
- R4: With the block enabled and no restart write, a tick strobe on count 7 sets the count to 0 and raises the reset request at the same clock edge.
- R5: The reset request is never high for two cycles in a row.
- R6: A write with bit 3 set clears the count at that clock edge and suppresses the request, even when a tick strobe arrives in the same cycle on count 7.
- R7: A write with bit 3 clear has no effect on the count or the request; bits 2 to 0 of any write are ignored.
- R8: Bit 3 of the read word is always 0, and bits 2 to 0 always equal the count, with bit 0 as the least significant bit.
- R9: With the enable low, the count is held at 0 and the reset request stays low, whatever ticks and writes arrive. When the enable rises, counting starts from 0.
- R10: After a restart, the reset request comes with exactly the eighth tick strobe that follows, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_en_i | input | 1 | Static function enable (1 = watchdog active) |
| tick_2hz_i | input | 1 | One-cycle strobe at 2 Hz from the clock-timer prescaler |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 4 | Write data; bit 3 = restart |
| rd_data_o | output | 4 | Read word: bit 3 reads 0, bits 2..0 = count |
| rst_req_o | output | 1 | One-cycle initial-reset request on overflow |

## Verification
The counter is driven three ways: with sparse strobes separated by idle cycles, which shows that stepping follows the tick and not the clock; with a strobe held high on every cycle, which exposes any off-by-one in the overflow; and with the enable low. Restart writes land at several counts, one of them in the same cycle as the overflow strobe, which separates the priority of restart over wrap. Writes with bit 3 clear and other bits set are mixed in to show that they leave the count alone. The number of strobes from a restart to the request is counted to confirm the eight-tick timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Action chosen for the counter in one cycle, in priority order of decode
    typedef enum logic [1:0] {
        WDT_ACT_HOLD  = 2'd0,
        WDT_ACT_STEP  = 2'd1,
        WDT_ACT_WRAP  = 2'd2,
        WDT_ACT_CLEAR = 2'd3
    } wdt_act_e;

    localparam int unsigned WDT_CNT_W_DEF  = 3;
    localparam int unsigned WDT_REG_W_DEF  = 4;
    localparam int unsigned WDT_KICK_B_DEF = 3;

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W  = WDT_CNT_W_DEF,
    parameter int unsigned REG_W  = WDT_REG_W_DEF,
    parameter int unsigned KICK_B = WDT_KICK_B_DEF
) (
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             kick_o,
    output logic [REG_W-1:0] rd_data_o
);

    // Only the restart bit of a write matters; all other written bits are dropped
    assign kick_o = wr_en_i & wr_data_i[KICK_B];

    // Read word: counter stages in the low bits, restart bit and spares read 0
    for (genvar i = 0; i < REG_W; i++) begin : g_rd
        if (i < CNT_W && i != KICK_B) begin : g_stage
            assign rd_data_o[i] = cnt_i[i];
        end else begin : g_zero
            assign rd_data_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     kick_i,
    input  logic     tick_i,
    input  logic     at_max_i,
    output wdt_act_e act_o
);

    // Priority: disable, then restart, then tick (wrap or step), else hold
    always_comb begin
        if (!en_i || kick_i) begin
            act_o = WDT_ACT_CLEAR;
        end else if (tick_i) begin
            act_o = at_max_i ? WDT_ACT_WRAP : WDT_ACT_STEP;
        end else begin
            act_o = WDT_ACT_HOLD;
        end
    end

    // R6: a restart in the overflow cycle must never produce a wrap
    p_kick_beats_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |-> act_o == WDT_ACT_CLEAR);

    // R3: without tick, restart or disable the counter must hold
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !kick_i && !tick_i) |-> act_o == WDT_ACT_HOLD);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = WDT_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdt_act_e         act_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_max_o,
    output logic             req_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } wdt_state_t;

    wdt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        case (act_i)
            WDT_ACT_CLEAR: st_d.cnt = CNT_ZERO;
            WDT_ACT_STEP:  st_d.cnt = st_q.cnt + CNT_ONE;
            WDT_ACT_WRAP: begin
                st_d.cnt = CNT_ZERO;
                st_d.req = 1'b1;
            end
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign req_o    = st_q.req;
    assign at_max_o = &st_q.cnt;

    // R2: a step adds exactly one
    p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == WDT_ACT_STEP |=> st_q.cnt == CNT_W'($past(st_q.cnt) + CNT_ONE));

    // R4: a wrap clears the count and raises the request at the same edge
    p_wrap_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == WDT_ACT_WRAP |=> (st_q.req && st_q.cnt == CNT_ZERO));

    // R5: request is a single-cycle pulse
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> !st_q.req);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W  = WDT_CNT_W_DEF,
    parameter int unsigned REG_W  = WDT_REG_W_DEF,
    parameter int unsigned KICK_B = WDT_KICK_B_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_en_i,
    input  logic             tick_2hz_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             rst_req_o
);

    logic [CNT_W-1:0] cnt;
    logic             at_max;
    logic             kick;
    wdt_act_e         act;

    wdt_regif #(.CNT_W(CNT_W), .REG_W(REG_W), .KICK_B(KICK_B)) u_regif (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cnt_i     (cnt),
        .kick_o    (kick),
        .rd_data_o (rd_data_o)
    );

    wdt_action u_action (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (wdt_en_i),
        .kick_i   (kick),
        .tick_i   (tick_2hz_i),
        .at_max_i (at_max),
        .act_o    (act)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .cnt_o    (cnt),
        .at_max_o (at_max),
        .req_o    (rst_req_o)
    );

    // R9: disabled block holds zero and never requests reset
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en_i |=> (rd_data_o == '0 && !rst_req_o));

    // R6: a restart write clears the readable count with no request
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[KICK_B]) |=> (rd_data_o == '0 && !rst_req_o));

    // R8: the restart bit never reads as one
    p_kick_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[KICK_B] == 1'b0);

endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_en_i = 1'b0;
    logic       tick_2hz_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_data_i = 4'h0;
    logic [3:0] rd_data_o;
    logic       rst_req_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference
    int m_cnt = 0;
    bit m_req = 1'b0;

    always #5 clk = ~clk;

    wdt_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdt_en_i   (wdt_en_i),
        .tick_2hz_i (tick_2hz_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .rst_req_o  (rst_req_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare after it
    task automatic step(string tag, bit en, bit tk, bit wr, logic [3:0] d);
        @(negedge clk);
        wdt_en_i = en; tick_2hz_i = tk; wr_en_i = wr; wr_data_i = d;
        @(posedge clk);
        if (!en) begin
            m_cnt = 0; m_req = 1'b0;
        end else if (wr && d[3]) begin
            m_cnt = 0; m_req = 1'b0;
        end else if (tk) begin
            if (m_cnt == 7) begin m_cnt = 0; m_req = 1'b1; end
            else begin m_cnt = m_cnt + 1; m_req = 1'b0; end
        end else begin
            m_req = 1'b0;
        end
        #1;
        check({tag, " count"}, int'(rd_data_o[2:0]), m_cnt);
        check({tag, " request"}, int'(rst_req_o), int'(m_req));
        check("R8 restart bit reads 0", int'(rd_data_o[3]), 0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        int ticks;
        int fired_at;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset count", int'(rd_data_o), 0);
        check("R1 reset request", int'(rst_req_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wdt_en_i = 1'b1;
        @(posedge clk); #1;
        check("R1 first cycle count", int'(rd_data_o), 0);
        check("R1 first cycle request", int'(rst_req_o), 0);

        // R2 / R3: sparse ticks with idle gaps
        for (int i = 0; i < 5; i++) begin
            step("R2 tick step", 1, 1, 0, 4'h0);
            repeat (3) step("R3 idle hold", 1, 0, 0, 4'h0);
        end

        // R7: write with bit 3 clear, together with a tick and alone
        step("R7 write 0111 with tick", 1, 1, 1, 4'h7);
        step("R7 write 0101 alone", 1, 0, 1, 4'h5);

        // R4 / R5: reach 7 and overflow, then quiet
        while (m_cnt != 7) step("R2 approach max", 1, 1, 0, 4'h0);
        step("R4 overflow", 1, 1, 0, 4'h0);
        check("R4 pulse seen", int'(rst_req_o), 1);
        step("R5 pulse ends", 1, 0, 0, 4'h0);
        check("R5 request low", int'(rst_req_o), 0);

        // R6: restart mid count, then restart on the overflow cycle
        repeat (5) step("R2 count up", 1, 1, 0, 4'h0);
        step("R6 restart at 5", 1, 0, 1, 4'h8);
        check("R6 cleared", int'(rd_data_o), 0);
        repeat (7) step("R2 count up", 1, 1, 0, 4'h0);
        step("R6 restart beats wrap", 1, 1, 1, 4'hF);
        check("R6 no request", int'(rst_req_o), 0);

        // R10: exactly eight ticks after a restart, ticks spaced out
        step("R6 restart", 1, 0, 1, 4'h8);
        ticks = 0; fired_at = 0;
        for (int i = 0; i < 10; i++) begin
            step("R10 timeout tick", 1, 1, 0, 4'h0);
            ticks++;
            if (rst_req_o && fired_at == 0) fired_at = ticks;
            step("R10 timeout gap", 1, 0, 0, 4'h0);
        end
        check("R10 ticks to request", fired_at, 8);

        // R5 / R4 with tick held every cycle
        step("R6 restart", 1, 0, 1, 4'h8);
        for (int i = 0; i < 20; i++) step("R5 continuous ticks", 1, 1, 0, 4'h0);

        // R9: disabled, ticks and writes do nothing
        step("R9 disable", 0, 1, 0, 4'h0);
        for (int i = 0; i < 20; i++) begin
            step("R9 disabled tick", 0, 1, 0, 4'h0);
            step("R9 disabled write", 0, 0, 1, 4'h7);
        end
        check("R9 quiet count", int'(rd_data_o), 0);
        step("R9 enable from zero", 1, 1, 0, 4'h0);
        check("R9 first count after enable", int'(rd_data_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule